// File: doc/BRIEF.md
# Multi-Lane Serial Register Port

This block is the target side of a serial link that reads and writes a small bank of configuration registers. A host clocks it with a serial clock and selects it with an active-low chip select. Four data pins carry 1, 2 or 4 bits per clock. The lane width and the bit order are themselves fields of a control register that the host writes over the same link. A new setting is used from the next chip-select assertion onward.

Each transfer begins with an instruction byte. Bit 7 selects a read (1) or a write (0), and bits 6:0 give the register address. A fixed number of data bytes follows. That number is `address[1:0] + 1`, so it ranges from one to four. Address 0 is the control register and lives inside the port. All other addresses go to an external register file through a parallel write port and a combinational read port. For reads, the port starts driving on the falling clock edge after the instruction byte, so the host can sample on the next rising edge. Data pin 3 doubles as a sync input, forwarded to `sync_o`, whenever it is not needed as a data lane.

Top module: `lane_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, which means lane mode 00 and MSB first. All output enables are low and `wr_en` is low.
- R2: An instruction byte with bit 7 set starts a read and with bit 7 clear starts a write. Its bits 6:0 are the address, and `address[1:0] + 1` data bytes follow it.
- R3: On the rising edge that completes each write data byte, the port raises `wr_en` for exactly one clock. `wr_addr`, `wr_byte` (0 for the first data byte) and `wr_data` carry that byte. Writes to address 0 raise no strobe.
- R4: Address 0 holds the control register. Bits 1:0 are the lane mode and bit 2 selects LSB-first. Reads of address 0 return it, and a written value takes effect from the next chip-select assertion.
- R5: In mode 00, one bit per clock travels on `sdio_i[0]`. Read data is driven on `sdio_o[0]`, with output-enable mask 0001.
- R6: In mode 01, one bit per clock arrives on `sdio_i[0]`. Read data is driven on `sdio_o[2]` with mask 0100, and the enable of pin 0 is never raised.
- R7: In mode 10, two bits move per clock and a byte takes 4 clocks. Pin 1 carries the odd-numbered bit and pin 0 the even-numbered bit of each pair, in both bit orders. The read mask is 0011.
- R8: In mode 11, four bits move per clock and a byte takes 2 clocks. Pins 3:0 carry nibble bits 3:0. The read mask is 1111, raised only during the read data phase.
- R9: MSB-first sends bit 7 (or the top pair or nibble) first. LSB-first sends bit 0 (or the bottom pair or nibble) first.
- R10: Read data for each group appears after the falling edge that precedes the rising edge on which the host samples it. The first group appears after the falling edge that follows the last instruction bit.
- R11: Raising chip select mid-transfer releases every output enable at once. A partial byte is discarded without a strobe, and the next transfer decodes from a fresh bit count.
- R12: `sync_o` follows `sdio_i[3]` in modes 00, 01 and 10, and is 0 in mode 11. The enable of pin 3 is raised only in mode 11.
- R13: Data bytes beyond the address's byte count are ignored, with no strobe, until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs sampled on the rising edge, read data launched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts and idles the port |
| sdio_i | input | 4 | Data pin input values |
| sdio_o | output | 4 | Data pin output values |
| sdio_oe | output | 4 | Data pin output enables |
| sync_o | output | 1 | Sync signal taken from data pin 3 when it is not a data lane |
| rd_addr | output | AW | Register address of the current read |
| rd_byte | output | 2 | Byte index of the current read |
| rd_data | input | 8 | Register file read data for `rd_addr`/`rd_byte` |
| wr_en | output | 1 | One-clock write strobe |
| wr_addr | output | AW | Address of the byte being written |
| wr_byte | output | 2 | Byte index within the register being written |
| wr_data | output | 8 | Byte being written |

## Verification
The assertions assume that the serial clock keeps running while chip select is high, so that a write strobe clears on the next edge. They also assume that chip select changes only while the clock is low. The bench drives every input and chip-select change shortly after a falling edge and keeps the clock free-running through idle gaps. During read phases it holds the data inputs at zero and never drives pins that the port may enable. It changes lane mode only through completed control-register writes, so the mode latch never sees a value written mid-transfer.

// File: rtl/lane_serial_port.sv
module lane_serial_port #(
  parameter int AW = 7,
  parameter int BW = 2
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic [3:0]    sdio_i,
  output logic [3:0]    sdio_o,
  output logic [3:0]    sdio_oe,
  output logic          sync_o,
  output logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_byte,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [BW-1:0] wr_byte,
  output logic [7:0]    wr_data
);

  logic [2:0]    ctrl_q;
  logic          started, in_data, done, is_rd, lsb_q;
  logic [1:0]    mode_q;
  logic [3:0]    cnt;
  logic [7:0]    acc, nb, rb;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bidx, blast;
  logic [1:0]    cur_mode;
  logic          cur_lsb, byte_end;
  logic [3:0]    w, base, og;

  assign cur_mode = started ? mode_q : ctrl_q[1:0];
  assign cur_lsb  = started ? lsb_q  : ctrl_q[2];
  assign w        = (cur_mode == 2'b11) ? 4'd4 : (cur_mode == 2'b10) ? 4'd2 : 4'd1;
  assign base     = cur_lsb ? cnt : 4'd8 - cnt - w;
  assign byte_end = (cnt + w == 4'd8);
  assign sync_o   = (cur_mode != 2'b11) & sdio_i[3];
  assign rd_addr  = addr_q;
  assign rd_byte  = bidx;
  assign rb       = (addr_q == '0) ? {5'b0, ctrl_q} : rd_data;

  always_comb begin
    nb = acc;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] d;
      d = 4'(k) - base;
      if (4'(k) >= base && 4'(k) < base + w) nb[k] = sdio_i[d[1:0]];
    end
  end

  always_comb begin
    og = '0;
    for (int j = 0; j < 4; j++)
      if (4'(j) < w) og[j] = rb[3'(base + 4'(j))];
  end

  always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n || cs_n) begin
      started <= 1'b0; in_data <= 1'b0; done <= 1'b0; is_rd <= 1'b0;
      mode_q  <= '0;   lsb_q   <= 1'b0; cnt  <= '0;   acc   <= '0;
      addr_q  <= '0;   bidx    <= '0;   blast <= '0;
    end else begin
      started <= 1'b1;
      mode_q  <= cur_mode;
      lsb_q   <= cur_lsb;
      if (!done) begin
        cnt <= byte_end ? 4'd0 : cnt + w;
        acc <= byte_end ? 8'd0 : nb;
        if (byte_end) begin
          if (!in_data) begin
            in_data <= 1'b1;
            is_rd   <= nb[7];
            addr_q  <= nb[AW-1:0];
            bidx    <= '0;
            blast   <= nb[BW-1:0];
          end else if (bidx == blast) begin
            done <= 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_byte <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (in_data && !done && !is_rd && byte_end) begin
        if (addr_q == '0) ctrl_q <= nb[2:0];
        else begin
          wr_en   <= 1'b1;
          wr_addr <= addr_q;
          wr_byte <= bidx;
          wr_data <= nb;
        end
      end
    end
  end

  always_ff @(negedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n || cs_n) begin
      sdio_o <= '0; sdio_oe <= '0;
    end else if (in_data && is_rd && !done) begin
      case (cur_mode)
        2'b00:   begin sdio_o <= {3'b0, og[0]};       sdio_oe <= 4'b0001; end
        2'b01:   begin sdio_o <= {1'b0, og[0], 2'b0}; sdio_oe <= 4'b0100; end
        2'b10:   begin sdio_o <= {2'b0, og[1:0]};     sdio_oe <= 4'b0011; end
        default: begin sdio_o <= og;                  sdio_oe <= 4'b1111; end
      endcase
    end else begin
      sdio_oe <= '0;
    end
  end

  a_r11_oe_idle: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> sdio_oe == 4'b0);
  a_r3_one_cycle: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r3_no_ctrl_strobe: assert property (@(posedge sclk) disable iff (!rst_n)
    wr_en |-> wr_addr != '0);
  a_r8_oe_read_only: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (sdio_oe != 4'b0) |-> is_rd);
  a_r6_pin0_input: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (started && mode_q == 2'b01) |-> !sdio_oe[0]);
  a_r12_pin3_input: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (started && mode_q != 2'b11) |-> !sdio_oe[3]);

endmodule

// File: tb/sim_lane_serial_port.sv
`timescale 1ns/1ps
module sim_lane_serial_port;
  logic       sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [3:0] sdio_i = '0;
  logic [3:0] sdio_o, sdio_oe;
  logic       sync_o, wr_en;
  logic [6:0] rd_addr, wr_addr;
  logic [1:0] rd_byte, wr_byte;
  logic [7:0] rd_data, wr_data;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0]  mem    [0:127][0:3];
  logic [7:0]  shadow [0:127][0:3];
  logic [16:0] exp_q[$];
  logic [1:0]  tb_mode = 2'b00;
  logic        tb_lsb  = 1'b0;
  logic [2:0]  tb_ctrl = 3'b000;

  always #2.5 sclk = ~sclk;

  assign rd_data = mem[rd_addr][rd_byte];

  lane_serial_port u0 (.sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sync_o(sync_o), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .wr_data(wr_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int width();
    return (tb_mode == 2'b11) ? 4 : (tb_mode == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [3:0] oe_mask();
    case (tb_mode)
      2'b00: return 4'b0001;
      2'b01: return 4'b0100;
      2'b10: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int gbase(input int g);
    return tb_lsb ? g * width() : 8 - (g + 1) * width();
  endfunction

  task automatic put_grp(input logic [7:0] b, input int n);
    for (int g = 0; g < n; g++) begin
      logic [3:0] v;
      v = '0;
      for (int j = 0; j < width(); j++) v[j] = b[gbase(g) + j];
      @(negedge sclk); #1;
      cs_n = 1'b0; sdio_i = v;
      @(posedge sclk);
    end
  endtask

  task automatic get_grp(output logic [7:0] b, input int n, input string req);
    b = '0;
    for (int g = 0; g < n; g++) begin
      logic [3:0] l;
      @(negedge sclk); #1;
      chk(sdio_oe == oe_mask(), req, sdio_oe, oe_mask());
      l = (tb_mode == 2'b01) ? {3'b0, sdio_o[2]} : sdio_o;
      for (int j = 0; j < width(); j++) b[gbase(g) + j] = l[j];
      @(posedge sclk);
    end
  endtask

  task automatic end_xfer();
    @(negedge sclk); #1;
    cs_n = 1'b1; sdio_i = '0;
    repeat (2) @(posedge sclk);
  endtask

  task automatic wr(input logic [6:0] a, input int nsend, input logic [31:0] d);
    put_grp({1'b0, a}, 8 / width());
    for (int i = 0; i < nsend; i++) begin
      put_grp(d[8*i +: 8], 8 / width());
      if (i <= int'(a[1:0])) begin
        if (a == 0) tb_ctrl = d[2:0];
        else begin
          exp_q.push_back({a, 2'(i), d[8*i +: 8]});
          shadow[a][i] = d[8*i +: 8];
        end
      end
    end
    end_xfer();
    tb_mode = tb_ctrl[1:0];
    tb_lsb  = tb_ctrl[2];
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    put_grp({1'b1, a}, 8 / width());
    for (int i = 0; i <= int'(a[1:0]); i++) begin
      logic [7:0] got, exp;
      get_grp(got, 8 / width(), req);
      exp = (a == 0) ? {5'b0, tb_ctrl} : shadow[a][i];
      chk(got == exp, req, got, exp);
    end
    end_xfer();
  endtask

  initial begin
    for (int a = 0; a < 128; a++) for (int b = 0; b < 4; b++) mem[a][b] = '0;
    forever begin
      @(negedge sclk);
      if (wr_en) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected strobe", {wr_addr, wr_byte, wr_data}, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_byte, wr_data} == e, "R3 write strobe", {wr_addr, wr_byte, wr_data}, e);
        end
        mem[wr_addr][wr_byte] = wr_data;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tmp;
    for (int a = 0; a < 128; a++) for (int b = 0; b < 4; b++) shadow[a][b] = '0;
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge sclk);
    #1;
    chk(sdio_oe == 0, "R1 oe after reset", sdio_oe, 0);
    chk(wr_en == 0, "R1 strobe after reset", wr_en, 0);
    rd(7'd0, "R1 control reset value");

    sdio_i[3] = 1'b1; #1;
    chk(sync_o == 1'b1, "R12 sync in mode 00", sync_o, 1);
    sdio_i[3] = 1'b0;

    wr(7'd1, 2, 32'h0000_3CA5);
    rd(7'd1, "R5 R10 R2 mode 00 readback");

    wr(7'd0, 1, 32'h1);
    rd(7'd0, "R6 R4 mode 01 control readback");
    wr(7'd6, 3, 32'h0011_2233);
    rd(7'd6, "R6 mode 01 readback");

    wr(7'd0, 1, 32'h2);
    wr(7'd2, 3, 32'h00C3_5A96);
    rd(7'd2, "R7 mode 10 msb readback");
    wr(7'd0, 1, 32'h6);
    wr(7'd3, 4, 32'h8142_2418);
    rd(7'd3, "R7 R9 mode 10 lsb readback");

    wr(7'd0, 1, 32'h3);
    sdio_i[3] = 1'b1; #1;
    chk(sync_o == 1'b0, "R12 sync off in mode 11", sync_o, 0);
    sdio_i[3] = 1'b0;
    wr(7'd5, 2, 32'h0000_E71D);
    rd(7'd5, "R8 mode 11 msb readback");
    wr(7'd0, 1, 32'h7);
    wr(7'd9, 2, 32'h0000_4BD2);
    rd(7'd9, "R8 R9 mode 11 lsb readback");

    wr(7'd0, 1, 32'h0);
    wr(7'd7, 4, 32'hF00F_5AA5);
    rd(7'd7, "R9 mode 00 msb four bytes");
    wr(7'd0, 1, 32'h4);
    rd(7'd7, "R9 mode 00 lsb four bytes");

    put_grp({1'b0, 7'd1}, 8);
    put_grp(8'hFF, 4);
    end_xfer();
    rd(7'd1, "R11 partial write discarded");

    put_grp({1'b1, 7'd1}, 8);
    get_grp(tmp, 3, "R11 partial read");
    end_xfer();
    #1;
    chk(sdio_oe == 0, "R11 oe released on abort", sdio_oe, 0);

    wr(7'd4, 3, 32'h0077_6655);
    rd(7'd4, "R13 extra bytes ignored");

    repeat (4) @(posedge sclk);
    chk(exp_q.size() == 0, "R3 R13 all strobes seen", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule